// File: doc/BRIEF.md
# Field-Aware Blank and Sync End Timer

This block sits in a video timing chain and decides when vertical blanking and the horizontal sync pulse end. It runs on the double-rate sample clock. A field-start strobe with an odd/even flag opens each field, and a line-start strobe opens each scan line. Two 8-bit programmable values set the timing: a base line number for the end of blanking, and a half-resolution count for the end of sync.

A line counter is set to 1 by the field-start strobe and advances on every line-start strobe. Blanking rises at each field start. It falls on the line given by the base value plus an offset, and that offset depends on the field parity and on the line standard (525 or 625 lines). A horizontal counter is cleared by each line-start strobe, which is count 0 and the leading edge of sync. Sync falls when that counter reaches twice the programmed value. Both programmed values and the standard select are sampled only at a field start, so a field always runs on one consistent setting.

Top module: `vid_blank_sync_timer`

## Requirements
- R1: While reset is applied, and after it is released until the first strobe, both `vblank` and `hsync` read 1.
- R2: On an odd field (`field_even`=0 at the field start), with base value n, `vblank` falls on the clock edge that samples the line-start strobe which makes the line count n+5. The field-start strobe sets the count to 1 and each later line-start strobe adds one.
- R3: `vblank` reads 1 on the edge after a field-start strobe. A field-start strobe that arrives in the same cycle as a line-start strobe takes priority, and the count restarts at 1.
- R4: On an even field in 525-line mode (`std_625`=0), `vblank` falls when the line count reaches n+268.
- R5: On an even field in 625-line mode (`std_625`=1), `vblank` falls when the line count reaches n+318.
- R6: With a nonzero sync value h, `hsync` reads 1 from the edge that samples a line-start strobe. It stays 1 for exactly 2*h clock cycles.
- R7: With h = 0, `hsync` reads 0 for the whole line that follows a line-start strobe.
- R8: Changes to `blank_end_reg`, `hsync_end_reg` and `std_625` have no effect until the next field-start strobe. Lines in the current field keep the values sampled at the last field start.
- R9: Once `hsync` has fallen, it stays 0 until the next line-start strobe, however long the line runs (the horizontal counter saturates).
- R10: The largest sync value, h = 255, gives a pulse width of 510 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Double-rate sample clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| field_start | input | 1 | One-cycle strobe that opens a field |
| field_even | input | 1 | Field parity, sampled with `field_start` (1 = even field) |
| line_start | input | 1 | One-cycle strobe at the leading edge of each line's sync |
| std_625 | input | 1 | Line standard, sampled at field start: 0 = 525 lines, 1 = 625 lines |
| blank_end_reg | input | 8 | Base line number n for the end of blanking |
| hsync_end_reg | input | 8 | Sync end value h; the pulse lasts 2*h cycles |
| vblank | output | 1 | Vertical blank, active high, registered |
| hsync | output | 1 | Horizontal sync, active high, registered |

## Verification
The assertions rely on the strobes being single-cycle pulses that are sampled on the clock. They expect blanking and sync to rise only in response to a strobe, and blanking to fall only on a line-start cycle. They also take it that no strobe arrives during the two synchronizer cycles after reset is released. The stimulus changes every input on the falling clock edge, holds each strobe for exactly one cycle, and waits several cycles after reset before the first strobe. It only changes the programmed values between strobes, because sync-width measurements depend on the field-start latch.

// File: rtl/vbs_pkg.sv
package vbs_pkg;

  localparam int REG_W = 8;

  typedef struct packed {
    logic [REG_W-1:0] blank_base;
    logic [REG_W-1:0] hs_end;
    logic             std625;
    logic             even;
  } vbs_cfg_t;

endpackage

// File: rtl/vbs_rst_sync.sv
module vbs_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/vbs_field_shadow.sv
module vbs_field_shadow
  import vbs_pkg::*;
#(
  parameter logic [REG_W-1:0] BLANK_RST = 8'h12,
  parameter logic [REG_W-1:0] HS_RST    = 8'h00
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             field_start,
  input  logic             field_even,
  input  logic             std_625,
  input  logic [REG_W-1:0] blank_end_reg,
  input  logic [REG_W-1:0] hsync_end_reg,
  output vbs_cfg_t         cfg
);

  vbs_cfg_t cfg_q;
  vbs_cfg_t cfg_d;
  logic     load_en;

  // sample the settings only at a field boundary
  assign load_en = field_start;

  always_comb begin
    cfg_d            = cfg_q;
    cfg_d.blank_base = blank_end_reg;
    cfg_d.hs_end     = hsync_end_reg;
    cfg_d.std625     = std_625;
    cfg_d.even       = field_even;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q.blank_base <= BLANK_RST;
      cfg_q.hs_end     <= HS_RST;
      cfg_q.std625     <= 1'b0;
      cfg_q.even       <= 1'b0;
    end else if (load_en) begin
      cfg_q <= cfg_d;
    end
  end

  assign cfg = cfg_q;

endmodule

// File: rtl/vbs_hsync_gen.sv
module vbs_hsync_gen
  import vbs_pkg::*;
#(
  parameter int HCNT_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_start,
  input  logic [REG_W-1:0] hs_end,
  output logic             hsync
);

  localparam logic [HCNT_W-1:0] HCNT_MAX = {HCNT_W{1'b1}};

  logic [HCNT_W-1:0] hcnt_q, hcnt_d;
  logic [HCNT_W-1:0] end_cnt;
  logic              hcnt_en;
  logic              at_max;
  logic              hit_end;
  logic              hs_q, hs_d;

  // end count in double-rate cycles is the register value times two
  assign end_cnt = HCNT_W'({hs_end, 1'b0});
  assign at_max  = (hcnt_q == HCNT_MAX);
  assign hcnt_en = line_start || !at_max;
  assign hit_end = !at_max && ((hcnt_q + 1'b1) == end_cnt);

  always_comb begin
    hcnt_d = hcnt_q;
    if (line_start) begin
      hcnt_d = '0;
    end else if (!at_max) begin
      hcnt_d = hcnt_q + 1'b1;
    end
  end

  always_comb begin
    hs_d = hs_q;
    if (line_start) begin
      hs_d = (end_cnt != '0);
    end else if (hit_end) begin
      hs_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt_q <= '0;
    end else if (hcnt_en) begin
      hcnt_q <= hcnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_q <= 1'b1;
    end else begin
      hs_q <= hs_d;
    end
  end

  assign hsync = hs_q;

endmodule

// File: rtl/vbs_vblank_gen.sv
module vbs_vblank_gen
  import vbs_pkg::*;
#(
  parameter int LINE_W       = 10,
  parameter int ODD_OFS      = 5,
  parameter int EVEN_OFS_525 = 268,
  parameter int EVEN_OFS_625 = 318
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     field_start,
  input  logic     line_start,
  input  vbs_cfg_t cfg,
  output logic     vblank
);

  localparam logic [LINE_W-1:0] LINE_MAX = {LINE_W{1'b1}};

  logic [LINE_W-1:0] line_q, line_d;
  logic [LINE_W-1:0] offset;
  logic [LINE_W-1:0] target;
  logic              line_en;
  logic              at_max;
  logic              hit_target;
  logic              vb_q, vb_d;

  always_comb begin
    if (!cfg.even) begin
      offset = LINE_W'(ODD_OFS);
    end else if (cfg.std625) begin
      offset = LINE_W'(EVEN_OFS_625);
    end else begin
      offset = LINE_W'(EVEN_OFS_525);
    end
  end

  assign target     = LINE_W'(cfg.blank_base) + offset;
  assign at_max     = (line_q == LINE_MAX);
  assign line_en    = field_start || (line_start && !at_max);
  assign hit_target = line_start && !at_max && ((line_q + 1'b1) == target);

  always_comb begin
    line_d = line_q;
    if (field_start) begin
      line_d = LINE_W'(1);
    end else if (line_start && !at_max) begin
      line_d = line_q + 1'b1;
    end
  end

  always_comb begin
    vb_d = vb_q;
    if (field_start) begin
      vb_d = 1'b1;
    end else if (hit_target) begin
      vb_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q <= '0;
    end else if (line_en) begin
      line_q <= line_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vb_q <= 1'b1;
    end else begin
      vb_q <= vb_d;
    end
  end

  assign vblank = vb_q;

endmodule

// File: rtl/vid_blank_sync_timer.sv
module vid_blank_sync_timer
  import vbs_pkg::*;
#(
  parameter int RST_STAGES   = 2,
  parameter int HCNT_W       = 9,
  parameter int LINE_W       = 10,
  parameter int ODD_OFS      = 5,
  parameter int EVEN_OFS_525 = 268,
  parameter int EVEN_OFS_625 = 318
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       field_start,
  input  logic       field_even,
  input  logic       line_start,
  input  logic       std_625,
  input  logic [7:0] blank_end_reg,
  input  logic [7:0] hsync_end_reg,
  output logic       vblank,
  output logic       hsync
);

  logic     rst_sync_n;
  vbs_cfg_t cfg;

  vbs_rst_sync #(
    .STAGES(RST_STAGES)
  ) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  vbs_field_shadow u_shadow (
    .clk           (clk),
    .rst_n         (rst_sync_n),
    .field_start   (field_start),
    .field_even    (field_even),
    .std_625       (std_625),
    .blank_end_reg (blank_end_reg),
    .hsync_end_reg (hsync_end_reg),
    .cfg           (cfg)
  );

  vbs_hsync_gen #(
    .HCNT_W(HCNT_W)
  ) u_hsync (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .line_start (line_start),
    .hs_end     (cfg.hs_end),
    .hsync      (hsync)
  );

  vbs_vblank_gen #(
    .LINE_W       (LINE_W),
    .ODD_OFS      (ODD_OFS),
    .EVEN_OFS_525 (EVEN_OFS_525),
    .EVEN_OFS_625 (EVEN_OFS_625)
  ) u_vblank (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .field_start (field_start),
    .line_start  (line_start),
    .cfg         (cfg),
    .vblank      (vblank)
  );

endmodule

// File: rtl/vbs_timer_chk.sv
module vbs_timer_chk (
  input logic clk,
  input logic rst_n,
  input logic field_start,
  input logic line_start,
  input logic vblank,
  input logic hsync
);

  // R3
  vblank_after_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
    field_start |=> vblank);

  // R3
  vblank_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vblank) |-> $past(field_start));

  // R2
  vblank_fall_on_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(vblank) |-> ($past(line_start) && !$past(field_start)));

  // R6
  hsync_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hsync) |-> $past(line_start));

  // R9
  hsync_low_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hsync && !line_start) |=> !hsync);

endmodule

bind vid_blank_sync_timer vbs_timer_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .field_start (field_start),
  .line_start  (line_start),
  .vblank      (vblank),
  .hsync       (hsync)
);

// File: tb/vid_blank_sync_timer_bench.sv
`timescale 1ns/1ps
module vid_blank_sync_timer_bench;

  logic       clk;
  logic       rst_n;
  logic       field_start;
  logic       field_even;
  logic       line_start;
  logic       std_625;
  logic [7:0] blank_end_reg;
  logic [7:0] hsync_end_reg;
  logic       vblank;
  logic       hsync;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  vid_blank_sync_timer u_vid_blank_sync_timer (
    .clk           (clk),
    .rst_n         (rst_n),
    .field_start   (field_start),
    .field_even    (field_even),
    .line_start    (line_start),
    .std_625       (std_625),
    .blank_end_reg (blank_end_reg),
    .hsync_end_reg (hsync_end_reg),
    .vblank        (vblank),
    .hsync         (hsync)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // columns: std625, even, n, h, expected drop line, expected hsync width
  localparam int NVEC = 6;
  localparam int VEC [NVEC][6] = '{
    '{0, 0,  18,   32,  23,  64},
    '{0, 1,  18,    0, 286,   0},
    '{1, 1,  48,  255, 366, 510},
    '{1, 0,   0,    1,   5,   2},
    '{0, 1, 255,   64, 523, 128},
    '{1, 1, 255,    3, 573,   6}
  };

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic strobe(input logic fs, input logic ls);
    field_start = fs;
    line_start  = ls;
    @(negedge clk);
    field_start = 1'b0;
    line_start  = 1'b0;
  endtask

  task automatic measure_width(output int w);
    w = 0;
    for (int i = 0; i < 520; i++) begin
      if (hsync) w++;
      @(negedge clk);
    end
  endtask

  // after the field start has already been given and line = 1
  task automatic run_lines(input int start_line, output int drop_line);
    int line;
    line = start_line;
    drop_line = -1;
    while (vblank && line < 700) begin
      strobe(1'b0, 1'b1);
      line++;
      if (!vblank) drop_line = line;
      @(negedge clk);
      @(negedge clk);
    end
  endtask

  initial begin
    int w;
    int dl;
    rst_n = 1'b0;
    field_start = 1'b0;
    field_even = 1'b0;
    line_start = 1'b0;
    std_625 = 1'b0;
    blank_end_reg = 8'd0;
    hsync_end_reg = 8'd0;
    repeat (3) @(negedge clk);
    check("R1 vblank in reset", int'(vblank), 1);
    check("R1 hsync in reset", int'(hsync), 1);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    check("R1 vblank after release", int'(vblank), 1);
    check("R1 hsync after release", int'(hsync), 1);

    for (int v = 0; v < NVEC; v++) begin
      std_625       = VEC[v][0][0];
      field_even    = VEC[v][1][0];
      blank_end_reg = 8'(VEC[v][2]);
      hsync_end_reg = 8'(VEC[v][3]);
      strobe(1'b1, 1'b0);
      check("R3 vblank after field start", int'(vblank), 1);
      strobe(1'b0, 1'b1);
      measure_width(w);
      check("R6/R7/R10 hsync width", w, VEC[v][5]);
      if (vblank) begin
        run_lines(2, dl);
      end else begin
        dl = 2;
      end
      check("R2/R4/R5 blank end line", dl, VEC[v][4]);
    end

    // R9: a long line with no strobe keeps hsync low after it falls
    repeat (1000) @(negedge clk);
    check("R9 hsync stays low", int'(hsync), 0);

    // R8: new values wait for the next field start (shadow holds h=3, 625 even)
    hsync_end_reg = 8'd10;
    blank_end_reg = 8'd0;
    std_625       = 1'b0;
    field_even    = 1'b0;
    strobe(1'b0, 1'b1);
    measure_width(w);
    check("R8 old hsync width before field start", w, 6);
    strobe(1'b1, 1'b0);
    strobe(1'b0, 1'b1);
    measure_width(w);
    check("R8 new hsync width after field start", w, 20);
    run_lines(2, dl);
    check("R8 new blank end line", dl, 5);

    // R3: simultaneous strobes, field start wins and the count restarts
    blank_end_reg = 8'd2;
    field_even    = 1'b0;
    strobe(1'b1, 1'b1);
    check("R3 vblank on simultaneous strobes", int'(vblank), 1);
    run_lines(1, dl);
    check("R3 line count restarts at 1", dl, 7);

    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule